// File: doc/BRIEF.md
# Asynchronous Static Memory Strobe Controller

This block serves one external asynchronous static memory bank, such as SRAM or NOR flash. It accepts single read or write requests over a valid/ready handshake and turns each one into timed chip-select, output-enable, write-enable and byte-lane strobes. It drives the address and, for writes only, the bidirectional data bus. Strobe lengths come from programmable wait counts. A set of static configuration inputs picks the chip-select sense, the way the byte-lane strobes behave, four-word page bursts for reads, and a long shared wait used in place of the separate read and write waits.

The controller is a five-state machine:
- `ST_IDLE`: every pin is inactive. A request is accepted here and the state moves to `ST_RD` or `ST_WR`.
- `ST_RD`: the read strobe is active. When the wait counter reaches zero, ready is raised. The state then moves to `ST_PG_HOLD` if page mode is on and the burst has fewer than four beats, and to `ST_IDLE` otherwise.
- `ST_PG_HOLD`: one cycle in which chip select and output enable stay active. A read to the same four-word page returns to `ST_RD` with the short page wait. Anything else goes to `ST_IDLE`.
- `ST_WR`: the write strobe is active. When the counter reaches zero the state moves to `ST_WR_HOLD`.
- `ST_WR_HOLD`: write enable is released, the data bus is still driven and ready is raised. The state then moves to `ST_IDLE`.

Because every single access leaves through `ST_IDLE`, there is always at least one quiet cycle between two accesses that are not part of a burst.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, chip select is at its inactive level, output enable, write enable and all byte-lane strobes are high, and ready is low.
- R2: With `cfg_cs_high`=0 chip select is active low. With `cfg_cs_high`=1 it is active high.
- R3: A read holds chip select and output enable active for `cfg_wait_rd`+1 cycles. Ready is high in the last of these cycles, and `rsp_rdata` carries the data bus in that cycle.
- R4: A write holds its strobe for `cfg_wait_wr`+1 cycles and then spends one hold cycle with ready high. Chip select is active for `cfg_wait_wr`+2 cycles in total.
- R5: With `cfg_lane_rd`=0, all strobes in `mem_bls_n` (bit i is byte lane i) stay high on reads, and `mem_we_n` stays high throughout. On writes, only lanes whose `req_be` bit is 1 go low.
- R6: With `cfg_lane_rd`=1, lanes whose `req_be` bit is 1 go low on both reads and writes, and `mem_we_n` is low for exactly the write strobe cycles.
- R7: The data bus is driven with the write data only from the first write-enable cycle through the hold cycle that follows it.
- R8: With `cfg_ext_wait`=1, both reads and writes use a strobe of (`cfg_wait_ext`+1)×16 cycles in place of the separate waits.
- R9: With `cfg_page_en`=1, a read to the same four-word page (word address bits above bit 1 equal) that is presented in the cycle after a read completes continues the burst. Chip select stays active, and that beat spans `cfg_wait_page`+2 cycles.
- R10: A burst never exceeds four beats. A fifth read, or a read outside the page, starts a fresh access after a quiet cycle, using the full read wait.
- R11: After a non-burst access, the next cycle has chip select inactive and output enable, write enable and all lane strobes high.
- R12: Output enable is never active while write enable is low, and it is high at the completion of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cs_high | input | 1 | Chip-select sense: 1 = active high |
| cfg_lane_rd | input | 1 | Byte-lane mode: 1 = lanes strobe on reads and write enable is used |
| cfg_page_en | input | 1 | Enable four-word page read bursts |
| cfg_ext_wait | input | 1 | Use the extended shared wait |
| cfg_wait_rd | input | 5 | Read wait count |
| cfg_wait_wr | input | 5 | Write wait count |
| cfg_wait_page | input | 5 | Wait count for later burst beats |
| cfg_wait_ext | input | 10 | Extended wait count, in units of 16 cycles |
| req_valid | input | 1 | Request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| req_ready | output | 1 | Request completes in this cycle |
| rsp_rdata | output | 32 | Read data, valid while ready is high on a read |
| mem_cs | output | 1 | Chip select, sense set by `cfg_cs_high` |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls_n | output | 4 | Byte-lane strobes, active low |
| mem_addr | output | 20 | External word address |
| mem_dq | inout | 32 | Bidirectional data bus |

## Verification
The request is taken at the first rising edge on which it is valid. For a read, chip select becomes active after that edge, and ready appears in the cycle `cfg_wait_rd`+1 after it, or (`cfg_wait_ext`+1)×16 after it in extended mode. A write raises ready one cycle later, in its hold cycle. A later burst beat raises ready `cfg_wait_page`+2 cycles after the previous beat's ready. The bench never predicts an absolute cycle. A monitor samples every falling edge, counts consecutive chip-select-active cycles and write-enable-low cycles, and compares those counts, the lane pattern and the data against the queued expectation in the cycle ready is high. The quiet-cycle check is made on the falling edge directly after that.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD      = 3'd1,
        ST_PG_HOLD = 3'd2,
        ST_WR      = 3'd3,
        ST_WR_HOLD = 3'd4
    } ctrl_state_e;

    // extended wait counts in units of 2**EXT_SHIFT clocks
    localparam int EXT_SHIFT = 4;

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // a non-zero load cannot expire on the next cycle
    AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !done); // R3

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_ctrl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  ctrl_state_e      state,
    input  logic             cfg_cs_high,
    input  logic             cfg_lane_rd,
    input  logic [LANES-1:0] be,
    output logic             cs_act,
    output logic             mem_cs,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic [LANES-1:0] mem_bls_n,
    output logic             dq_oe
);

    logic rd_phase;
    logic wr_strobe;
    logic wr_phase;

    always_comb begin
        rd_phase  = (state == ST_RD) || (state == ST_PG_HOLD);
        wr_strobe = (state == ST_WR);
        wr_phase  = wr_strobe || (state == ST_WR_HOLD);
        cs_act    = rd_phase || wr_phase;
        mem_cs    = cfg_cs_high ? cs_act : ~cs_act;
        mem_oe_n  = ~rd_phase;
        mem_we_n  = ~(wr_strobe && cfg_lane_rd);
        dq_oe     = wr_phase;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mem_bls_n[g] = ~(be[g] && (wr_strobe || (rd_phase && cfg_lane_rd)));
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 32,
    parameter int RW_W      = 5,
    parameter int EXT_W     = 10,
    parameter int BURST_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cs_high,
    input  logic                cfg_lane_rd,
    input  logic                cfg_page_en,
    input  logic                cfg_ext_wait,
    input  logic [RW_W-1:0]     cfg_wait_rd,
    input  logic [RW_W-1:0]     cfg_wait_wr,
    input  logic [RW_W-1:0]     cfg_wait_page,
    input  logic [EXT_W-1:0]    cfg_wait_ext,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                req_ready,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_cs,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [DATA_W/8-1:0] mem_bls_n,
    output logic [ADDR_W-1:0]   mem_addr,
    inout  wire  [DATA_W-1:0]   mem_dq
);

    localparam int LANES     = DATA_W / 8;
    localparam int CNT_W     = EXT_W + EXT_SHIFT;
    localparam int PAGE_BITS = $clog2(BURST_LEN);
    localparam logic [PAGE_BITS-1:0] BEAT_LAST = PAGE_BITS'(BURST_LEN - 1);

    ctrl_state_e state_q, state_d;

    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [LANES-1:0]     be_q;
    logic [PAGE_BITS-1:0] beat_q;

    logic             accept_new;
    logic             accept_beat;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             same_page;
    logic             cs_act;
    logic             dq_oe;

    logic [CNT_W-1:0] wait_ext_full;
    logic [CNT_W-1:0] wait_rd_full;
    logic [CNT_W-1:0] wait_wr_full;

    assign wait_ext_full = {cfg_wait_ext, {EXT_SHIFT{1'b1}}};
    assign wait_rd_full  = cfg_ext_wait ? wait_ext_full : CNT_W'(cfg_wait_rd);
    assign wait_wr_full  = cfg_ext_wait ? wait_ext_full : CNT_W'(cfg_wait_wr);

    assign same_page = (req_addr[ADDR_W-1:PAGE_BITS] == addr_q[ADDR_W-1:PAGE_BITS]);

    // next-state and counter-load decision
    always_comb begin
        state_d     = state_q;
        accept_new  = 1'b0;
        accept_beat = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept_new = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = req_write ? wait_wr_full : wait_rd_full;
                    state_d    = req_write ? ST_WR : ST_RD;
                end
            end
            ST_RD: begin
                if (tmr_done) begin
                    state_d = (cfg_page_en && beat_q != BEAT_LAST) ? ST_PG_HOLD : ST_IDLE;
                end
            end
            ST_PG_HOLD: begin
                if (req_valid && !req_write && same_page) begin
                    accept_beat = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(cfg_wait_page);
                    state_d     = ST_RD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR: begin
                if (tmr_done) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept_new || accept_beat) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            if (accept_new) begin
                beat_q <= '0;
            end else if (accept_beat) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    sram_wait_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_pin_drive #(
        .LANES (LANES)
    ) i_pins (
        .state       (state_q),
        .cfg_cs_high (cfg_cs_high),
        .cfg_lane_rd (cfg_lane_rd),
        .be          (be_q),
        .cs_act      (cs_act),
        .mem_cs      (mem_cs),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_bls_n   (mem_bls_n),
        .dq_oe       (dq_oe)
    );

    // handshake and bus outputs
    assign req_ready = ((state_q == ST_RD) && tmr_done) || (state_q == ST_WR_HOLD);
    assign rsp_rdata = mem_dq;
    assign mem_addr  = addr_q;
    assign mem_dq    = dq_oe ? wdata_q : {DATA_W{1'bz}};

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R3

    AST_DRIVE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> mem_oe_n); // R7

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R12

    AST_WE_LANE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> cfg_lane_rd); // R5

    AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_act) |-> (mem_oe_n && mem_we_n && (&mem_bls_n))); // R11

    AST_BURST_PAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PG_HOLD) |-> cfg_page_en); // R9

    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PG_HOLD) |-> (beat_q != BEAT_LAST)); // R10

endmodule

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

    localparam int AW = 20;
    localparam int DW = 32;

    typedef struct {
        bit          wr;
        logic [31:0] data;
        int          len;
        logic [3:0]  bls;
        int          welow;
        bit          gap;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cs_high = 1'b0, cfg_lane_rd = 1'b0, cfg_page_en = 1'b0, cfg_ext_wait = 1'b0;
    logic [4:0] cfg_wait_rd = 5'd3, cfg_wait_wr = 5'd2, cfg_wait_page = 5'd1;
    logic [9:0] cfg_wait_ext = 10'd1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3:0] req_be = '0;
    logic req_ready;
    logic [DW-1:0] rsp_rdata;
    logic mem_cs, mem_oe_n, mem_we_n;
    logic [3:0] mem_bls_n;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] mem_dq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    function automatic logic [31:0] mem_word(logic [AW-1:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // memory model drives the bus while output enable is low
    assign mem_dq = (!mem_oe_n) ? mem_word(mem_addr) : {DW{1'bz}};

    sram_strobe_ctrl i_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_cs_high(cfg_cs_high), .cfg_lane_rd(cfg_lane_rd),
        .cfg_page_en(cfg_page_en), .cfg_ext_wait(cfg_ext_wait),
        .cfg_wait_rd(cfg_wait_rd), .cfg_wait_wr(cfg_wait_wr),
        .cfg_wait_page(cfg_wait_page), .cfg_wait_ext(cfg_wait_ext),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_bls_n(mem_bls_n), .mem_addr(mem_addr),
        .mem_dq(mem_dq)
    );

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int strobe_rd();
        return cfg_ext_wait ? (int'(cfg_wait_ext) + 1) * 16 : int'(cfg_wait_rd) + 1;
    endfunction

    function automatic int strobe_wr();
        return cfg_ext_wait ? (int'(cfg_wait_ext) + 1) * 16 : int'(cfg_wait_wr) + 1;
    endfunction

    // driver: queue the expectation, then hold the request until ready
    task automatic do_req(bit wr, logic [AW-1:0] a, logic [31:0] d, logic [3:0] be,
                          int len, bit gap, string tag);
        item_t it;
        it.wr    = wr;
        it.data  = wr ? d : mem_word(a);
        it.len   = len;
        it.bls   = (wr || cfg_lane_rd) ? ~be : 4'hF;
        it.welow = (wr && cfg_lane_rd) ? len - 1 : 0;
        it.gap   = gap;
        it.tag   = tag;
        sb_q.push_back(it);
        req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [3:0] be, int len, bit gap, string tag);
        do_req(1'b0, a, '0, be, len, gap, tag);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] be, bit gap, string tag);
        do_req(1'b1, a, d, be, strobe_wr() + 1, gap, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: count strobe cycles and compare at each completion
    int   run_len = 0;
    int   we_len  = 0;
    bit   gap_due = 1'b0;
    logic [3:0] prev_bls = 4'hF;
    logic cs_on;
    item_t cur;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cs_on = cfg_cs_high ? mem_cs : ~mem_cs;
            if (gap_due) begin
                chk(!cs_on && mem_oe_n && mem_we_n && (mem_bls_n == 4'hF), "R11",
                    "quiet cycle {cs,oe_n,we_n,bls_n}",
                    {cs_on, mem_oe_n, mem_we_n, mem_bls_n}, {1'b0, 1'b1, 1'b1, 4'hF});
                gap_due = 1'b0;
            end
            if (cs_on) run_len++; else run_len = 0;
            if (!cs_on) we_len = 0;
            if (!mem_we_n) begin
                we_len++;
                chk(mem_oe_n, "R12", "oe_n while we low", mem_oe_n, 1);
                if (sb_q.size() > 0)
                    chk(mem_dq == sb_q[0].data, "R7", "bus during write strobe", mem_dq, sb_q[0].data);
            end
            if (req_ready) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected ready", 1, 0);
                end else begin
                    cur = sb_q.pop_front();
                    chk(run_len == cur.len, cur.tag, "strobe span", run_len, cur.len);
                    chk(we_len == cur.welow, cfg_lane_rd ? "R6" : "R5", "we low cycles", we_len, cur.welow);
                    if (cur.wr) begin
                        chk(prev_bls == cur.bls, cfg_lane_rd ? "R6" : "R5", "write lanes", prev_bls, cur.bls);
                        chk(mem_dq == cur.data, "R7", "bus in hold cycle", mem_dq, cur.data);
                        chk(mem_oe_n && mem_we_n, "R12", "oe_n/we_n at write end", {mem_oe_n, mem_we_n}, 2'b11);
                    end else begin
                        chk(mem_bls_n == cur.bls, cfg_lane_rd ? "R6" : "R5", "read lanes", mem_bls_n, cur.bls);
                        chk(rsp_rdata == cur.data, "R3", "read data", rsp_rdata, cur.data);
                    end
                    gap_due = cur.gap;
                end
                run_len = 0;
                we_len  = 0;
            end
            prev_bls = mem_bls_n;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state, low-active chip select
        chk(mem_cs == 1'b1 && mem_oe_n && mem_we_n && mem_bls_n == 4'hF && !req_ready, "R1",
            "reset pins {cs,oe_n,we_n,bls_n,ready}",
            {mem_cs, mem_oe_n, mem_we_n, mem_bls_n, req_ready}, {1'b1, 1'b1, 1'b1, 4'hF, 1'b0});
        rst_n = 1'b1;
        idle(2);
        chk(mem_cs == 1'b1, "R2", "idle cs with low sense", mem_cs, 1);

        // R3/R4/R5: low sense, byte-lane mode 0
        rd(20'h00010, 4'hF, strobe_rd(), 1'b1, "R3");
        wr(20'h00011, 32'hCAFE_0001, 4'h5, 1'b1, "R4");
        rd(20'h00123, 4'h3, strobe_rd(), 1'b1, "R5");
        idle(2);

        // R2: high sense
        cfg_cs_high = 1'b1;
        idle(1);
        chk(mem_cs == 1'b0, "R2", "idle cs with high sense", mem_cs, 0);
        rd(20'h00200, 4'hF, strobe_rd(), 1'b1, "R2");
        wr(20'h00201, 32'h1234_5678, 4'hA, 1'b1, "R2");
        idle(2);

        // R6: byte-lane mode 1
        cfg_lane_rd = 1'b1;
        rd(20'h00300, 4'h3, strobe_rd(), 1'b1, "R6");
        wr(20'h00301, 32'h0BAD_F00D, 4'hC, 1'b1, "R6");
        wr(20'h00302, 32'hFFFF_0000, 4'h1, 1'b1, "R4");
        idle(2);

        // R8: extended wait for both directions
        cfg_ext_wait = 1'b1;
        rd(20'h00400, 4'hF, strobe_rd(), 1'b1, "R8");
        wr(20'h00401, 32'h5555_AAAA, 4'hF, 1'b1, "R8");
        cfg_ext_wait = 1'b0;
        idle(2);

        // R3 boundary: zero read and write wait
        cfg_wait_rd = 5'd0;
        cfg_wait_wr = 5'd0;
        rd(20'h00500, 4'hF, strobe_rd(), 1'b1, "R3");
        wr(20'h00501, 32'h0000_0042, 4'h2, 1'b1, "R4");
        cfg_wait_rd = 5'd3;
        cfg_wait_wr = 5'd2;
        idle(2);

        // R9/R10: four-beat page burst, then restart paths
        cfg_page_en = 1'b1;
        rd(20'h00640, 4'hF, strobe_rd(), 1'b0, "R9");
        rd(20'h00641, 4'hF, int'(cfg_wait_page) + 2, 1'b0, "R9");
        rd(20'h00643, 4'h3, int'(cfg_wait_page) + 2, 1'b0, "R9");
        rd(20'h00642, 4'hF, int'(cfg_wait_page) + 2, 1'b1, "R10");
        rd(20'h00644, 4'hF, strobe_rd(), 1'b0, "R10");
        rd(20'h00680, 4'hF, strobe_rd(), 1'b0, "R10");
        wr(20'h00681, 32'hDEAD_BEEF, 4'hF, 1'b1, "R4");
        idle(4);
        chk(sb_q.size() == 0, "R3", "outstanding expectations", sb_q.size(), 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule